// File: doc/BRIEF.md
# String Operation Index Stepper

This block keeps the source index, destination index and repeat count of a string-copy engine and moves them forward by one element each time a step strobe arrives. The element may be one byte, or two, four or eight bytes according to the operand-size code. The direction bit picks between counting up and counting down. The address-size code picks how many low bits of each index take part in the wrap: 16, 32 or the whole register. When the address is narrower than the register, the bits above the address width keep their value.

A repeat flag turns the step into one pass of a counted loop. If the count is zero, the step transfers no element and leaves all state alone. If the count is not zero, the element moves and the count drops by one. The block also forms two effective addresses from the current indices. The read address is the data segment base, or an override base, plus the masked source index. The write address is the extra segment base plus the masked destination index. A load strobe seeds all three registers. Memory access belongs to the surrounding logic.

Top module: `strop_idx_stepper`

## Requirements
- R1: A synchronous active-high reset clears the source index, destination index and count to zero.
- R2: On a clock edge with load_i high, the three registers take load_src_i, load_dst_i and load_cnt_i. A step strobe in the same cycle is ignored.
- R3: The element size is 1 byte when byte_i is 1. Otherwise op_w_i selects it: 0 gives 2 bytes, 1 gives 4 bytes, 2 gives 8 bytes. With dir_dn_i at 0 an index gains the element size, and with dir_dn_i at 1 it loses the element size.
- R4: With ad_w_i 0 (16 bits) or 1 (32 bits), only the low 16 or 32 bits of a stepped index take the wrapped sum, and the upper bits keep their value.
- R5: With ad_w_i 2 the whole register is stepped, and a carry or borrow reaches its top bits.
- R6: kind_i selects which indices advance. 0 (move) advances both. 1 (store) advances only the destination index. 2 (load) advances only the source index.
- R7: With rep_i high and the count at zero, xfer_o is 0, and a step leaves both indices and the count unchanged.
- R8: With rep_i high and the count nonzero, iterate_o is 1, and a step lowers the count by one. With rep_i low, xfer_o is 1 and a step leaves the count unchanged.
- R9: done_o is 1 exactly when the count register is zero.
- R10: rd_addr_o equals the base (ovr_base_i if seg_ovr_i is 1, else ds_base_i) plus the source index masked to the address width. wr_addr_o equals es_base_i plus the destination index masked the same way. Both sums wrap at the register width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Seed the registers |
| load_src_i | input | REG_W | Seed value for the source index |
| load_dst_i | input | REG_W | Seed value for the destination index |
| load_cnt_i | input | REG_W | Seed value for the count |
| step_i | input | 1 | Advance by one element |
| kind_i | input | 2 | 0 move, 1 store, 2 load |
| byte_i | input | 1 | Byte-sized element |
| op_w_i | input | 2 | Operand size: 0 two bytes, 1 four bytes, 2 eight bytes |
| ad_w_i | input | 2 | Address width: 0 16 bits, 1 32 bits, 2 full register |
| dir_dn_i | input | 1 | Count the indices downward |
| rep_i | input | 1 | Repeat prefix present |
| seg_ovr_i | input | 1 | Read through the override base |
| ds_base_i | input | REG_W | Default read segment base |
| es_base_i | input | REG_W | Write segment base |
| ovr_base_i | input | REG_W | Override read segment base |
| src_o | output | REG_W | Source index |
| dst_o | output | REG_W | Destination index |
| cnt_o | output | REG_W | Repeat count |
| done_o | output | 1 | Count is zero |
| iterate_o | output | 1 | Repeat with count remaining |
| xfer_o | output | 1 | A step now would move an element |
| rd_addr_o | output | REG_W | Read effective address |
| wr_addr_o | output | REG_W | Write effective address |

## Verification
The assertions assume that the reserved code 3 never appears on kind_i, op_w_i or ad_w_i while step_i is high. They also assume that load_i wins over step_i, so they qualify every step property with load_i low. The stimulus drives only the legal codes. It changes the controls only between clock edges, and it pairs load with step in a single, deliberate cycle that tests precedence.

// File: rtl/strop_pkg.sv
package strop_pkg;

    typedef enum logic [1:0] {
        STR_MOVE  = 2'd0,
        STR_STORE = 2'd1,
        STR_LOAD  = 2'd2,
        STR_RSVD  = 2'd3
    } str_kind_e;

    typedef enum logic [1:0] {
        WID_16   = 2'd0,
        WID_32   = 2'd1,
        WID_FULL = 2'd2,
        WID_RSVD = 2'd3
    } wid_e;

    typedef struct packed {
        str_kind_e kind;
        logic      byte_form;
        wid_e      op_w;
        wid_e      ad_w;
        logic      dir_dn;
        logic      rep;
        logic      seg_ovr;
    } step_ctl_t;

    localparam int NUM_IDX = 2;
    localparam int IDX_SRC = 0;
    localparam int IDX_DST = 1;

    // Element size in bytes (R3)
    function automatic logic [3:0] elem_bytes(logic byte_form, wid_e op_w);
        logic [3:0] b;
        if (byte_form) begin
            b = 4'd1;
        end else begin
            case (op_w)
                WID_16:  b = 4'd2;
                WID_32:  b = 4'd4;
                default: b = 4'd8;
            endcase
        end
        return b;
    endfunction

    // Which index registers a string kind advances (R6)
    function automatic logic kind_moves(str_kind_e kind, int idx);
        logic m;
        case (kind)
            STR_MOVE:  m = 1'b1;
            STR_STORE: m = (idx == IDX_DST);
            STR_LOAD:  m = (idx == IDX_SRC);
            default:   m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/strop_addr_mask.sv
module strop_addr_mask
    import strop_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  wid_e             ad_w_i,
    output logic [REG_W-1:0] mask_o
);
    localparam logic [REG_W-1:0] ONES   = {REG_W{1'b1}};
    localparam logic [REG_W-1:0] MASK16 = ONES >> (REG_W - 16);
    localparam logic [REG_W-1:0] MASK32 = ONES >> (REG_W - 32);

    always_comb begin
        case (ad_w_i)
            WID_16:  mask_o = MASK16;
            WID_32:  mask_o = MASK32;
            default: mask_o = ONES;
        endcase
    end
endmodule

// File: rtl/strop_idx_adder.sv
module strop_idx_adder
    import strop_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0] cur_i,
    input  logic [REG_W-1:0] mask_i,
    input  logic [3:0]       bytes_i,
    input  logic             dir_dn_i,
    output logic [REG_W-1:0] nxt_o
);
    logic [REG_W-1:0] mag;
    logic [REG_W-1:0] delta;
    logic [REG_W-1:0] sum;

    always_comb begin
        mag   = {{(REG_W-4){1'b0}}, bytes_i};
        // negative step as two's complement: sign extended over the full register (R3)
        delta = dir_dn_i ? (~mag + {{(REG_W-1){1'b0}}, 1'b1}) : mag;
        sum   = cur_i + delta;
        // only bits inside the address width take the sum (R4, R5)
        nxt_o = (cur_i & ~mask_i) | (sum & mask_i);
    end
endmodule

// File: rtl/strop_ea_gen.sv
module strop_ea_gen #(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0] base_i,
    input  logic [REG_W-1:0] idx_i,
    input  logic [REG_W-1:0] mask_i,
    output logic [REG_W-1:0] ea_o
);
    // R10: base plus masked index, wraps at the register width
    assign ea_o = base_i + (idx_i & mask_i);
endmodule

// File: rtl/strop_rep_ctl.sv
module strop_rep_ctl #(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0] cnt_i,
    input  logic             rep_i,
    output logic             zero_o,
    output logic             xfer_o,
    output logic             iterate_o,
    output logic [REG_W-1:0] cnt_nxt_o
);
    always_comb begin
        zero_o    = (cnt_i == '0);
        xfer_o    = !(rep_i && zero_o);
        iterate_o = rep_i && !zero_o;
        cnt_nxt_o = iterate_o ? (cnt_i - {{(REG_W-1){1'b0}}, 1'b1}) : cnt_i;
    end
endmodule

// File: rtl/strop_idx_stepper.sv
module strop_idx_stepper
    import strop_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [REG_W-1:0] load_src_i,
    input  logic [REG_W-1:0] load_dst_i,
    input  logic [REG_W-1:0] load_cnt_i,
    input  logic             step_i,
    input  logic [1:0]       kind_i,
    input  logic             byte_i,
    input  logic [1:0]       op_w_i,
    input  logic [1:0]       ad_w_i,
    input  logic             dir_dn_i,
    input  logic             rep_i,
    input  logic             seg_ovr_i,
    input  logic [REG_W-1:0] ds_base_i,
    input  logic [REG_W-1:0] es_base_i,
    input  logic [REG_W-1:0] ovr_base_i,
    output logic [REG_W-1:0] src_o,
    output logic [REG_W-1:0] dst_o,
    output logic [REG_W-1:0] cnt_o,
    output logic             done_o,
    output logic             iterate_o,
    output logic             xfer_o,
    output logic [REG_W-1:0] rd_addr_o,
    output logic [REG_W-1:0] wr_addr_o
);
    step_ctl_t        ctl;
    logic [REG_W-1:0] idx_q    [NUM_IDX];
    logic [REG_W-1:0] idx_nxt  [NUM_IDX];
    logic [REG_W-1:0] seg_base [NUM_IDX];
    logic [REG_W-1:0] ea       [NUM_IDX];
    logic [NUM_IDX-1:0] adv;
    logic [REG_W-1:0] cnt_q;
    logic [REG_W-1:0] cnt_nxt;
    logic [REG_W-1:0] ad_mask;
    logic [3:0]       step_bytes;
    logic             cnt_zero;
    logic             xfer;
    logic             iterate;

    always_comb begin
        ctl.kind      = str_kind_e'(kind_i);
        ctl.byte_form = byte_i;
        ctl.op_w      = wid_e'(op_w_i);
        ctl.ad_w      = wid_e'(ad_w_i);
        ctl.dir_dn    = dir_dn_i;
        ctl.rep       = rep_i;
        ctl.seg_ovr   = seg_ovr_i;
    end

    assign step_bytes = elem_bytes(ctl.byte_form, ctl.op_w);

    strop_addr_mask #(.REG_W(REG_W)) u_mask (
        .ad_w_i (ctl.ad_w),
        .mask_o (ad_mask)
    );

    strop_rep_ctl #(.REG_W(REG_W)) u_rep (
        .cnt_i     (cnt_q),
        .rep_i     (ctl.rep),
        .zero_o    (cnt_zero),
        .xfer_o    (xfer),
        .iterate_o (iterate),
        .cnt_nxt_o (cnt_nxt)
    );

    // read side uses the default or override base, write side the extra base (R10)
    assign seg_base[IDX_SRC] = ctl.seg_ovr ? ovr_base_i : ds_base_i;
    assign seg_base[IDX_DST] = es_base_i;

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        assign adv[g] = kind_moves(ctl.kind, g);

        strop_idx_adder #(.REG_W(REG_W)) u_add (
            .cur_i    (idx_q[g]),
            .mask_i   (ad_mask),
            .bytes_i  (step_bytes),
            .dir_dn_i (ctl.dir_dn),
            .nxt_o    (idx_nxt[g])
        );

        strop_ea_gen #(.REG_W(REG_W)) u_ea (
            .base_i (seg_base[g]),
            .idx_i  (idx_q[g]),
            .mask_i (ad_mask),
            .ea_o   (ea[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                idx_q[g] <= '0;                           // R1
            end else if (load_i) begin
                idx_q[g] <= (g == IDX_SRC) ? load_src_i : load_dst_i;  // R2
            end else if (step_i && xfer && adv[g]) begin
                idx_q[g] <= idx_nxt[g];                   // R3 R6 R7
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_cnt_i;
        end else if (step_i) begin
            cnt_q <= cnt_nxt;                             // R8
        end
    end

    assign src_o     = idx_q[IDX_SRC];
    assign dst_o     = idx_q[IDX_DST];
    assign cnt_o     = cnt_q;
    assign done_o    = cnt_zero;                          // R9
    assign iterate_o = iterate;
    assign xfer_o    = xfer;
    assign rd_addr_o = ea[IDX_SRC];
    assign wr_addr_o = ea[IDX_DST];

endmodule

// File: rtl/strop_idx_stepper_chk.sv
module strop_idx_stepper_chk #(
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             load_i,
    input logic [REG_W-1:0] load_src_i,
    input logic             step_i,
    input logic [1:0]       kind_i,
    input logic             byte_i,
    input logic [1:0]       ad_w_i,
    input logic             dir_dn_i,
    input logic             rep_i,
    input logic [REG_W-1:0] src_o,
    input logic [REG_W-1:0] dst_o,
    input logic [REG_W-1:0] cnt_o
);
    logic stp;
    assign stp = step_i && !load_i;

    AST_LOAD_SEEDS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> src_o == $past(load_src_i));                                   // R2

    AST_FULL_INC: assert property (@(posedge clk) disable iff (rst)
        stp && !rep_i && kind_i == 2'd0 && byte_i && ad_w_i == 2'd2 && !dir_dn_i
        |=> src_o == $past(src_o) + 1);                                            // R5

    AST_NARROW_KEEP: assert property (@(posedge clk) disable iff (rst)
        stp && ad_w_i == 2'd0 |=> src_o[REG_W-1:16] == $past(src_o[REG_W-1:16]));  // R4

    AST_STORE_SRC_KEEP: assert property (@(posedge clk) disable iff (rst)
        stp && kind_i == 2'd1 |=> $stable(src_o));                                 // R6

    AST_LOAD_DST_KEEP: assert property (@(posedge clk) disable iff (rst)
        stp && kind_i == 2'd2 |=> $stable(dst_o));                                 // R6

    AST_REP_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        stp && rep_i && cnt_o == '0 |=> $stable(src_o) && $stable(dst_o) && $stable(cnt_o)); // R7

    AST_REP_DEC: assert property (@(posedge clk) disable iff (rst)
        stp && rep_i && cnt_o != '0 |=> cnt_o == $past(cnt_o) - 1);                // R8

    AST_NOREP_CNT: assert property (@(posedge clk) disable iff (rst)
        stp && !rep_i |=> $stable(cnt_o));                                         // R8

endmodule

bind strop_idx_stepper strop_idx_stepper_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .load_src_i (load_src_i),
    .step_i     (step_i),
    .kind_i     (kind_i),
    .byte_i     (byte_i),
    .ad_w_i     (ad_w_i),
    .dir_dn_i   (dir_dn_i),
    .rep_i      (rep_i),
    .src_o      (src_o),
    .dst_o      (dst_o),
    .cnt_o      (cnt_o)
);

// File: tb/strop_idx_stepper_tb.sv
`timescale 1ns/1ps
module strop_idx_stepper_tb;
    localparam int REG_W = 64;

    typedef struct packed {
        logic [1:0]  kind;
        logic        byt;
        logic [1:0]  ow;
        logic [1:0]  aw;
        logic        dn;
        logic        rep;
        logic [63:0] si;
        logic [63:0] di;
        logic [63:0] cnt;
        logic [63:0] esi;
        logic [63:0] edi;
        logic [63:0] ecnt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0,1'b1,2'd0,2'd2,1'b0,1'b0,64'h1000,64'h2000,64'd5,64'h1001,64'h2001,64'd5},
        '{2'd0,1'b0,2'd1,2'd1,1'b1,1'b1,64'h10,64'h20,64'd3,64'hC,64'h1C,64'd2},
        '{2'd1,1'b0,2'd2,2'd2,1'b0,1'b0,64'h100,64'h200,64'd7,64'h100,64'h208,64'd7},
        '{2'd2,1'b0,2'd0,2'd0,1'b0,1'b0,64'hAAAABBBBCCCCFFFF,64'h55,64'd1,64'hAAAABBBBCCCC0001,64'h55,64'd1},
        '{2'd0,1'b1,2'd0,2'd0,1'b1,1'b0,64'h1234000000010000,64'h0,64'd9,64'h123400000001FFFF,64'h000000000000FFFF,64'd9},
        '{2'd0,1'b0,2'd1,2'd1,1'b0,1'b0,64'hDEADBEEFFFFFFFFE,64'hFFFFFFFFFFFFFFFC,64'd4,64'hDEADBEEF00000002,64'hFFFFFFFF00000000,64'd4},
        '{2'd0,1'b0,2'd2,2'd2,1'b0,1'b0,64'h00000000FFFFFFFC,64'hFFFFFFFFFFFFFFFC,64'd0,64'h0000000100000004,64'h4,64'd0},
        '{2'd0,1'b1,2'd0,2'd2,1'b0,1'b1,64'h40,64'h80,64'd0,64'h40,64'h80,64'd0},
        '{2'd2,1'b1,2'd0,2'd1,1'b1,1'b1,64'h0,64'h77,64'd1,64'h00000000FFFFFFFF,64'h77,64'd0},
        '{2'd1,1'b0,2'd0,2'd2,1'b1,1'b1,64'h5,64'h1,64'h100,64'h5,64'hFFFFFFFFFFFFFFFF,64'hFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_i = 1'b0;
    logic [REG_W-1:0] load_src_i = '0, load_dst_i = '0, load_cnt_i = '0;
    logic step_i = 1'b0;
    logic [1:0] kind_i = 2'd0;
    logic byte_i = 1'b0;
    logic [1:0] op_w_i = 2'd0;
    logic [1:0] ad_w_i = 2'd0;
    logic dir_dn_i = 1'b0;
    logic rep_i = 1'b0;
    logic seg_ovr_i = 1'b0;
    logic [REG_W-1:0] ds_base_i = '0, es_base_i = '0, ovr_base_i = '0;
    logic [REG_W-1:0] src_o, dst_o, cnt_o, rd_addr_o, wr_addr_o;
    logic done_o, iterate_o, xfer_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    strop_idx_stepper #(.REG_W(REG_W)) u_dut (
        .clk(clk), .rst(rst), .load_i(load_i),
        .load_src_i(load_src_i), .load_dst_i(load_dst_i), .load_cnt_i(load_cnt_i),
        .step_i(step_i), .kind_i(kind_i), .byte_i(byte_i), .op_w_i(op_w_i),
        .ad_w_i(ad_w_i), .dir_dn_i(dir_dn_i), .rep_i(rep_i), .seg_ovr_i(seg_ovr_i),
        .ds_base_i(ds_base_i), .es_base_i(es_base_i), .ovr_base_i(ovr_base_i),
        .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .done_o(done_o),
        .iterate_o(iterate_o), .xfer_o(xfer_o), .rd_addr_o(rd_addr_o), .wr_addr_o(wr_addr_o)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_load(input logic [63:0] s, input logic [63:0] d, input logic [63:0] c);
        @(negedge clk);
        load_i = 1'b1; load_src_i = s; load_dst_i = d; load_cnt_i = c;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset src", src_o, 64'h0);
        chk("R1 reset dst", dst_o, 64'h0);
        chk("R1 reset cnt", cnt_o, 64'h0);
        chk("R9 done at reset", {63'd0, done_o}, 64'd1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].si, VECS[i].di, VECS[i].cnt);
            kind_i = VECS[i].kind; byte_i = VECS[i].byt; op_w_i = VECS[i].ow;
            ad_w_i = VECS[i].aw; dir_dn_i = VECS[i].dn; rep_i = VECS[i].rep;
            #1;
            chk($sformatf("vec %0d R7 R8 xfer", i), {63'd0, xfer_o},
                {63'd0, !(VECS[i].rep && VECS[i].cnt == 0)});
            chk($sformatf("vec %0d R9 done", i), {63'd0, done_o}, {63'd0, VECS[i].cnt == 0});
            do_step();
            chk($sformatf("vec %0d R3 R4 R5 R6 src", i), src_o, VECS[i].esi);
            chk($sformatf("vec %0d R3 R4 R5 R6 dst", i), dst_o, VECS[i].edi);
            chk($sformatf("vec %0d R7 R8 cnt", i), cnt_o, VECS[i].ecnt);
        end

        // R8: iterate flag with remaining count
        do_load(64'h0, 64'h0, 64'd3);
        rep_i = 1'b1; #1;
        chk("R8 iterate with count", {63'd0, iterate_o}, 64'd1);
        rep_i = 1'b0;

        // R2: load wins over a simultaneous step
        kind_i = 2'd0; byte_i = 1'b1; ad_w_i = 2'd2; dir_dn_i = 1'b0; rep_i = 1'b1;
        @(negedge clk);
        load_i = 1'b1; step_i = 1'b1;
        load_src_i = 64'h300; load_dst_i = 64'h400; load_cnt_i = 64'd6;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0; rep_i = 1'b0;
        chk("R2 load over step src", src_o, 64'h300);
        chk("R2 load over step dst", dst_o, 64'h400);
        chk("R2 load over step cnt", cnt_o, 64'd6);

        // R10: effective addresses
        do_load(64'h0000000180001234, 64'hFFFF000000000010, 64'd1);
        ds_base_i = 64'h1000; es_base_i = 64'h10000; ovr_base_i = 64'h500;
        seg_ovr_i = 1'b0; ad_w_i = 2'd0; #1;
        chk("R10 rd 16-bit", rd_addr_o, 64'h2234);
        chk("R10 wr 16-bit", wr_addr_o, 64'h10010);
        ad_w_i = 2'd1; #1;
        chk("R10 rd 32-bit", rd_addr_o, 64'h80002234);
        ad_w_i = 2'd2; #1;
        chk("R10 rd full", rd_addr_o, 64'h0000000180002234);
        chk("R10 wr full", wr_addr_o, 64'hFFFF000000010010);
        ad_w_i = 2'd0; seg_ovr_i = 1'b1; #1;
        chk("R10 rd override", rd_addr_o, 64'h1734);
        seg_ovr_i = 1'b0;

        // R9: done follows the count down to zero through repeated steps
        rep_i = 1'b1; kind_i = 2'd1; byte_i = 1'b1; ad_w_i = 2'd2; dir_dn_i = 1'b0;
        do_step();
        chk("R8 R9 count reached zero", cnt_o, 64'd0);
        chk("R9 done after last pass", {63'd0, done_o}, 64'd1);
        chk("R6 store moved dst", dst_o, 64'hFFFF000000000011);
        rep_i = 1'b0;

        finish_run();
    end
endmodule